// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible register file of a 16550-class serial port. A host reaches it over a byte-wide bus with a 3-bit offset, a select strobe and a write flag. Read data is combinational and valid in the cycle the select is high. Writes take effect at the clock edge that ends the access. The block holds the configuration: the baud divisor, the line format, the interrupt enables, the modem control lines, the FIFO mode and the scratch byte. It turns host accesses into single-cycle strobes for the neighbouring logic.

The shift registers, the FIFO storage and the interrupt arbiter sit outside this block. They connect through ports. Status from them (receive data available, transmit FIFO empty or full, the interrupt code) is folded into the status bytes the host reads back. Every data write goes either to the transmitter or, when loopback is on, straight into the receive path.

Top module: `uart_regfile`

Register offsets: 0 is the data buffer, or the divisor low byte when the access bit is set. 1 is the interrupt enable, or the divisor high byte when the access bit is set. 2 is interrupt identification on a read and FIFO control on a write. 3 is line control, 4 modem control, 5 line status, 6 modem status and 7 scratch.

## Requirements
- R1: With line control bit 7 set, offsets 0 and 1 read and write the divisor low and high bytes, and a write there drives neither tx_push nor lb_push. With bit 7 clear, offset 0 is the data buffer and offset 1 is the interrupt enable byte, which reads back whole and drives ier_en from its bits 3:0.
- R2: baud_div follows the 16-bit divisor formed by the two latch bytes. A write that would make that value zero leaves baud_div unchanged, while the written byte still reads back.
- R3: Line control reads back exactly as written, and word_len equals its bits 1:0.
- R4: Modem control bits 0..4 drive dtr, rts, out1, out2 and loopback. A read of modem control returns those five bits, with bits 7:5 read as zero.
- R5: A data write with loopback off pulses tx_push. With loopback on it pulses lb_push instead. In both cases char_out carries the written byte, and the two strobes are never high together.
- R6: Line status reads as follows. Bit 6 is always 1. Bit 0 equals rx_avail. Bit 5 equals tx_empty in FIFO mode and equals not tx_full otherwise. All other bits are 0.
- R7: Modem status reads the registered input lines in bits 7:4 and, in bits 3:0, the XOR of the last change's new and old line states. ms_event pulses in any cycle where modem_in differs from the registered lines.
- R8: A read of modem status clears bits 3:0 and keeps bits 7:4. If a line change lands in the same cycle, the read returns the old value and the new change flags survive.
- R9: A FIFO control write sets fifo_on from bit 0 and trig_lvl from bits 7:6. It pulses rx_flush for bit 1 and tx_flush for bit 2.
- R10: An identification read returns iir_code in bits 3:0 and 11 in bits 7:6 when fifo_on is set.
- R11: Read strobes are single-cycle. rx_pop pulses on a data-buffer read when rx_avail is high, and such a read returns rx_data, or 0 when nothing is available. lsr_rd, msr_rd and iir_rd pulse on reads of their registers. No other read pulses any strobe.
- R12: The scratch byte stores and returns any value and changes no other register.
- R13: After reset every register is zero and DLAB is clear, while the divisor latch and baud_div hold 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tx_push | output | 1 | Data write to the transmitter |
| lb_push | output | 1 | Data write looped into the receiver |
| char_out | output | 8 | Byte carried by tx_push / lb_push |
| rx_avail | input | 1 | Receive data present |
| rx_data | input | 8 | Head of the receive FIFO |
| rx_pop | output | 1 | Receive buffer consumed |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| fifo_on | output | 1 | FIFO mode selected |
| rx_flush | output | 1 | Clear the receive FIFO |
| tx_flush | output | 1 | Clear the transmit FIFO |
| trig_lvl | output | 2 | Receive trigger level code |
| iir_code | input | 4 | Current interrupt code from the arbiter |
| iir_rd | output | 1 | Identification register read |
| ier_en | output | 4 | Interrupt enables |
| baud_div | output | 16 | Effective baud divisor |
| word_len | output | 2 | Word length code |
| dtr | output | 1 | Modem control line 0 |
| rts | output | 1 | Modem control line 1 |
| out1 | output | 1 | Modem control line 2 |
| out2 | output | 1 | Modem control line 3 |
| loopback | output | 1 | Local loopback enable |
| modem_in | input | 4 | Modem status input lines |
| ms_event | output | 1 | Modem line change |
| lsr_rd | output | 1 | Line status read |
| msr_rd | output | 1 | Modem status read |

## Verification
Two modem status functions can fall in the same cycle: the clear-on-read of the change flags and the capture of a new line change. The bench sets up this collision by changing modem_in in the very cycle that it reads modem status. It judges the result in three steps. First, that read must return the old byte. Second, the next read must show the new lines together with the XOR against the previous lines. Third, the read after that must show the change flags cleared.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int DIV_W   = 2 * BYTE_W;
  localparam int LINES_W = BYTE_W / 2;
  localparam int MCR_W   = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA = 3'd0, OFS_IER = 3'd1, OFS_FIFO = 3'd2, OFS_LCR = 3'd3,
    OFS_MCR  = 3'd4, OFS_LSR = 3'd5, OFS_MSR  = 3'd6, OFS_SCR = 3'd7
  } reg_ofs_e;

  function automatic logic [BYTE_W-1:0] lsr_byte(logic rx_avail, logic fifo_mode,
                                                 logic tx_empty, logic tx_full);
    logic room;
    room = fifo_mode ? tx_empty : !tx_full;
    return {1'b0, 1'b1, room, 4'b0000, rx_avail};
  endfunction

  function automatic logic [BYTE_W-1:0] iir_byte(logic fifo_mode, logic [3:0] code);
    return {{2{fifo_mode}}, 2'b00, code};
  endfunction

  function automatic logic div_accept(logic [DIV_W-1:0] cand);
    return cand != '0;
  endfunction
endpackage

// File: rtl/uart_div_latch.sv
module uart_div_latch #(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [DIV_W/2-1:0] wdata,
  output logic [DIV_W/2-1:0] lo_q,
  output logic [DIV_W/2-1:0] hi_q,
  output logic [DIV_W-1:0]   div_eff
);
  import uart_regfile_pkg::*;
  localparam int HALF = DIV_W / 2;
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] cand;
  logic             load;

  always_comb begin
    cand = wr_lo ? {hi_q, wdata} : {wdata, lo_q};
    load = (wr_lo || wr_hi) && div_accept(cand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= RST_VAL[HALF-1:0];
      hi_q    <= RST_VAL[DIV_W-1:HALF];
      div_eff <= RST_VAL;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
      if (load)  div_eff <= cand;
    end
  end

  // R2
  div_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && {hi_q, wdata} == '0) |=> div_eff == $past(div_eff));
  // R2
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_eff != '0);
endmodule

// File: rtl/uart_msr_track.sv
module uart_msr_track #(
  parameter int LINES_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES_W-1:0] lines_in,
  input  logic               rd_clr,
  output logic [LINES_W-1:0] state_q,
  output logic [LINES_W-1:0] delta_q,
  output logic               change
);
  assign change = lines_in != state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      delta_q <= '0;
    end else if (change) begin
      state_q <= lines_in;
      delta_q <= lines_in ^ state_q;
    end else if (rd_clr) begin
      delta_q <= '0;
    end
  end

  // R8
  msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && lines_in == state_q) |=> (delta_q == '0 && $stable(state_q)));
  // R7
  msr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> state_q == $past(lines_in));
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int RESET_DIV = 1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    bus_sel,
  input  logic                                    bus_we,
  input  logic [uart_regfile_pkg::ADDR_W-1:0]     bus_addr,
  input  logic [uart_regfile_pkg::BYTE_W-1:0]     bus_wdata,
  output logic [uart_regfile_pkg::BYTE_W-1:0]     bus_rdata,
  output logic                                    tx_push,
  output logic                                    lb_push,
  output logic [uart_regfile_pkg::BYTE_W-1:0]     char_out,
  input  logic                                    rx_avail,
  input  logic [uart_regfile_pkg::BYTE_W-1:0]     rx_data,
  output logic                                    rx_pop,
  input  logic                                    tx_empty,
  input  logic                                    tx_full,
  output logic                                    fifo_on,
  output logic                                    rx_flush,
  output logic                                    tx_flush,
  output logic [1:0]                              trig_lvl,
  input  logic [3:0]                              iir_code,
  output logic                                    iir_rd,
  output logic [3:0]                              ier_en,
  output logic [uart_regfile_pkg::DIV_W-1:0]      baud_div,
  output logic [1:0]                              word_len,
  output logic                                    dtr,
  output logic                                    rts,
  output logic                                    out1,
  output logic                                    out2,
  output logic                                    loopback,
  input  logic [uart_regfile_pkg::LINES_W-1:0]    modem_in,
  output logic                                    ms_event,
  output logic                                    lsr_rd,
  output logic                                    msr_rd
);
  import uart_regfile_pkg::*;

  logic [BYTE_W-1:0]  lcr_q, ier_q, scr_q;
  logic [MCR_W-1:0]   mcr_q;
  logic               fifo_q;
  logic [1:0]         trig_q;
  logic [BYTE_W-1:0]  dl_lo, dl_hi;
  logic [LINES_W-1:0] ms_state, ms_delta;

  logic rd, wr, dlab;
  logic wr_dll, wr_dlm, wr_data, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;

  assign rd   = bus_sel && !bus_we;
  assign wr   = bus_sel && bus_we;
  assign dlab = lcr_q[BYTE_W-1];

  always_comb begin
    wr_dll  = wr && bus_addr == OFS_DATA && dlab;
    wr_dlm  = wr && bus_addr == OFS_IER  && dlab;
    wr_data = wr && bus_addr == OFS_DATA && !dlab;
    wr_ier  = wr && bus_addr == OFS_IER  && !dlab;
    wr_fcr  = wr && bus_addr == OFS_FIFO;
    wr_lcr  = wr && bus_addr == OFS_LCR;
    wr_mcr  = wr && bus_addr == OFS_MCR;
    wr_scr  = wr && bus_addr == OFS_SCR;
  end

  uart_div_latch #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_dll), .wr_hi(wr_dlm),
    .wdata(bus_wdata), .lo_q(dl_lo), .hi_q(dl_hi), .div_eff(baud_div)
  );

  uart_msr_track #(.LINES_W(LINES_W)) u_msr (
    .clk(clk), .rst_n(rst_n), .lines_in(modem_in), .rd_clr(msr_rd),
    .state_q(ms_state), .delta_q(ms_delta), .change(ms_event)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      ier_q  <= '0;
      scr_q  <= '0;
      mcr_q  <= '0;
      fifo_q <= 1'b0;
      trig_q <= '0;
    end else begin
      if (wr_lcr) lcr_q <= bus_wdata;
      if (wr_ier) ier_q <= bus_wdata;
      if (wr_scr) scr_q <= bus_wdata;
      if (wr_mcr) mcr_q <= bus_wdata[MCR_W-1:0];
      if (wr_fcr) begin
        fifo_q <= bus_wdata[0];
        trig_q <= bus_wdata[BYTE_W-1:BYTE_W-2];
      end
    end
  end

  assign tx_push  = wr_data && !mcr_q[4];
  assign lb_push  = wr_data &&  mcr_q[4];
  assign char_out = bus_wdata;
  assign rx_flush = wr_fcr && bus_wdata[1];
  assign tx_flush = wr_fcr && bus_wdata[2];

  assign rx_pop = rd && bus_addr == OFS_DATA && !dlab && rx_avail;
  assign lsr_rd = rd && bus_addr == OFS_LSR;
  assign msr_rd = rd && bus_addr == OFS_MSR;
  assign iir_rd = rd && bus_addr == OFS_FIFO;

  assign fifo_on  = fifo_q;
  assign trig_lvl = trig_q;
  assign ier_en   = ier_q[3:0];
  assign word_len = lcr_q[1:0];
  assign dtr      = mcr_q[0];
  assign rts      = mcr_q[1];
  assign out1     = mcr_q[2];
  assign out2     = mcr_q[3];
  assign loopback = mcr_q[4];

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata = dlab ? dl_lo : (rx_avail ? rx_data : '0);
        OFS_IER:  bus_rdata = dlab ? dl_hi : ier_q;
        OFS_FIFO: bus_rdata = iir_byte(fifo_q, iir_code);
        OFS_LCR:  bus_rdata = lcr_q;
        OFS_MCR:  bus_rdata = BYTE_W'(mcr_q);
        OFS_LSR:  bus_rdata = lsr_byte(rx_avail, fifo_q, tx_empty, tx_full);
        OFS_MSR:  bus_rdata = {ms_state, ms_delta};
        OFS_SCR:  bus_rdata = scr_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R5
  push_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_push, lb_push}));
  // R5
  loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> !tx_push);
  // R6
  lsr_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd |-> bus_rdata[6]);
  // R11
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_pop, lsr_rd, msr_rd, iir_rd}));
  // R1
  dlab_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dlab) |-> !(tx_push || lb_push));
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, char_out, rx_data = '0;
  logic tx_push, lb_push, rx_pop, rx_avail = 0, tx_empty = 0, tx_full = 0;
  logic fifo_on, rx_flush, tx_flush, iir_rd, ms_event, lsr_rd, msr_rd;
  logic [1:0] trig_lvl, word_len;
  logic [3:0] iir_code = '0, ier_en, modem_in = '0;
  logic [15:0] baud_div;
  logic dtr, rts, out1, out2, loopback;

  int vectors = 0, fails = 0;
  bit done = 0;

  typedef struct packed { logic [7:0] d; logic [3:0] p; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  uart_regfile u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_rd(input logic [2:0] a, input logic [7:0] d, input logic [3:0] p, input string tag);
    exp_q.push_back('{d: d, p: p});
    tag_q.push_back(tag);
    bus_sel = 1; bus_we = 0; bus_addr = a;
  endtask

  task automatic finish_acc();
    @(negedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic do_rd(input logic [2:0] a, input logic [7:0] d, input logic [3:0] p, input string tag);
    @(negedge clk); #1;
    put_rd(a, d, p, tag);
    finish_acc();
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d, input logic [1:0] push, input string tag);
    @(negedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1;
    chk({tx_push, lb_push} == push && (push == 2'b00 || char_out == d), tag,
        {tx_push, lb_push, char_out}, {push, d});
    finish_acc();
  endtask

  // scoreboard monitor: pulse order {rx_pop, lsr_rd, msr_rd, iir_rd}
  initial forever begin
    @(negedge clk); #3;
    if (bus_sel && !bus_we) begin
      if (exp_q.size() == 0) chk(0, "unexpected read", 0, 0);
      else begin
        exp_t e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(bus_rdata == e.d && {rx_pop, lsr_rd, msr_rd, iir_rd} == e.p, t,
            {bus_rdata, rx_pop, lsr_rd, msr_rd, iir_rd}, {e.d, e.p});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    #1 chk(baud_div == 16'd1 && word_len == 0 && {dtr, rts, out1, out2, loopback} == 0 &&
           ier_en == 0 && fifo_on == 0, "R13 reset outputs",
           {baud_div, word_len, dtr, rts, out1, out2, loopback}, 16'd1);
    do_rd(3, 8'h00, 4'b0000, "R13 lcr reset");
    do_rd(7, 8'h00, 4'b0000, "R13 scratch reset");

    // R1 R2 divisor access
    do_wr(3, 8'h83, 2'b00, "R3 lcr write");
    do_rd(0, 8'h01, 4'b0000, "R13 divisor low reset");
    do_wr(0, 8'h34, 2'b00, "R1 dll write no push");
    do_wr(1, 8'h12, 2'b00, "R1 dlm write");
    chk(baud_div == 16'h1234, "R2 divisor", baud_div, 16'h1234);
    do_rd(0, 8'h34, 4'b0000, "R1 dll read");
    do_rd(1, 8'h12, 4'b0000, "R1 dlm read");
    do_wr(0, 8'h00, 2'b00, "R2 low zero");
    chk(baud_div == 16'h1200, "R2 divisor 1200", baud_div, 16'h1200);
    do_wr(1, 8'h00, 2'b00, "R2 high zero");
    chk(baud_div == 16'h1200, "R2 zero ignored", baud_div, 16'h1200);
    do_rd(1, 8'h00, 4'b0000, "R2 dlm readback");
    do_rd(3, 8'h83, 4'b0000, "R3 lcr readback");

    // R3 R1 with DLAB clear
    do_wr(3, 8'h1B, 2'b00, "R3 lcr write");
    chk(word_len == 2'b11, "R3 word_len", word_len, 3);
    do_rd(3, 8'h1B, 4'b0000, "R3 lcr read");
    do_wr(1, 8'hAF, 2'b00, "R1 ier write");
    chk(ier_en == 4'hF, "R1 ier_en", ier_en, 4'hF);
    do_rd(1, 8'hAF, 4'b0000, "R1 ier read");

    // R4 modem control, R5 routing
    do_wr(4, 8'hFF, 2'b00, "R4 mcr write");
    chk({loopback, out2, out1, rts, dtr} == 5'h1F, "R4 mcr pins",
        {loopback, out2, out1, rts, dtr}, 5'h1F);
    do_rd(4, 8'h1F, 4'b0000, "R4 mcr read");
    do_wr(0, 8'h55, 2'b01, "R5 loopback write");
    do_wr(4, 8'h0A, 2'b00, "R4 mcr write 0a");
    chk({loopback, out2, out1, rts, dtr} == 5'h0A, "R4 mcr pins 0a",
        {loopback, out2, out1, rts, dtr}, 5'h0A);
    do_wr(0, 8'h66, 2'b10, "R5 tx write");

    // R6 line status
    rx_avail = 1; tx_full = 0;
    do_rd(5, 8'h61, 4'b0100, "R6 lsr nonfifo");
    tx_full = 1; rx_avail = 0;
    do_rd(5, 8'h40, 4'b0100, "R6 lsr full");

    // R9 fifo control
    @(negedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = 2; bus_wdata = 8'hC7;
    #1 chk(rx_flush && tx_flush, "R9 flush pulses", {rx_flush, tx_flush}, 2'b11);
    finish_acc();
    chk(fifo_on && trig_lvl == 2'b11, "R9 fifo mode", {fifo_on, trig_lvl}, 3'b111);
    do_wr(2, 8'h41, 2'b00, "R9 fcr no flush");
    chk(trig_lvl == 2'b01, "R9 trig", trig_lvl, 1);
    tx_empty = 0; tx_full = 0; rx_avail = 1;
    do_rd(5, 8'h41, 4'b0100, "R6 lsr fifo not empty");
    tx_empty = 1; rx_avail = 0;
    do_rd(5, 8'h60, 4'b0100, "R6 lsr fifo empty");

    // R10 identification
    iir_code = 4'h4;
    do_rd(2, 8'hC4, 4'b0001, "R10 iir fifo");
    do_wr(2, 8'h00, 2'b00, "R9 fifo off");
    iir_code = 4'h1;
    do_rd(2, 8'h01, 4'b0001, "R10 iir plain");

    // R11 receive buffer
    rx_avail = 1; rx_data = 8'hA5;
    do_rd(0, 8'hA5, 4'b1000, "R11 rbr pop");
    rx_avail = 0;
    do_rd(0, 8'h00, 4'b0000, "R11 rbr empty");

    // R7 R8 modem status
    @(negedge clk); #1 modem_in = 4'h5;
    #1 chk(ms_event == 1'b1, "R7 ms_event", ms_event, 1);
    do_rd(6, 8'h55, 4'b0010, "R7 msr change");
    do_rd(6, 8'h50, 4'b0010, "R8 msr cleared");
    @(negedge clk); #1;
    modem_in = 4'hC;
    put_rd(6, 8'h50, 4'b0010, "R8 collision old value");
    finish_acc();
    do_rd(6, 8'hC9, 4'b0010, "R8 collision flags kept");
    do_rd(6, 8'hC0, 4'b0010, "R8 cleared after collision");

    // R12 scratch
    do_wr(7, 8'h9C, 2'b00, "R12 scratch write");
    do_rd(7, 8'h9C, 4'b0000, "R12 scratch read");
    do_rd(3, 8'h1B, 4'b0000, "R12 lcr untouched");
    do_rd(1, 8'hAF, 4'b0000, "R12 ier untouched");
    chk(baud_div == 16'h1200, "R12 divisor untouched", baud_div, 16'h1200);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule